// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Line Forwarding

This block sits between a bank of up to 32 level-sensitive interrupt lines and a parent interrupt controller. It captures the lines into a status word, gates that word with a software-owned enable word, and folds the result onto a small number of group outputs. Each group output has an elaboration-time map mask that picks the lines it serves. The parent therefore sees a few summary lines, and software reads the status word to find the cause.

A few low-numbered lines can be forwarded instead. When a line's bit is set in the forward mask, its raw level goes straight to a dedicated output, and neither the enable word nor the status word sees it. Lines above the connected range are not wired. They never show in status and never reach an output. Software reaches the two registers through a one-bit word select inside an 8-byte window. There are no set or clear aliases, so any change to the enable word is a read-modify-write of the whole word.

Top module: `irq_l2_agg`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the enable word reads 0, the status word reads 0 and every group output is low.
- R2: A write with `reg_sel`=0 loads the enable word from `reg_wdata` masked to the connected lines (bits 0 to 11 by default). Reading with `reg_sel`=0 returns it, and bits 12 to 31 read 0.
- R3: The status word (`reg_sel`=1) is read-only. A write to it changes neither the enable word nor the status word.
- R4: Status bit i equals the level of `irq_lines[i]` sampled on the previous rising clock edge, for every connected line that is not forwarded.
- R5: Group output g rises or falls one clock after the status word. It equals the OR of status AND enable over the lines in map mask g. The defaults are 0xEB8 for output 0 (lines 3, 4, 5, 7, 9, 10, 11) and 0x140 for output 1 (lines 6, 8).
- R6: For a forwarded line i (forward mask 0x7, lines 0 to 2), `fwd_irq[i]` follows `irq_lines[i]` in the same cycle whatever the enable word holds, and status bit i reads 0.
- R7: Lines 12 to 31 never set a status bit and never move any output.
- R8: An enable write replaces the whole word. Bits set before the write but clear in the new value end up cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Word select in the 8-byte window: 0 enable, 1 status |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| irq_lines | input | 32 | Level-sensitive interrupt inputs |
| grp_irq | output | 2 | Group outputs to the parent controller |
| fwd_irq | output | 3 | Dedicated outputs for forwarded lines |

## Verification
The assertions check these on every cycle: group outputs against the inputs two clocks back and the enable word one clock back, enable loads and the ignored status writes, status bits staying zero for forwarded and unwired lines, and forward outputs never rising without their line. The bench sweeps all 4096 patterns of the connected lines under three enable words, with unwired bits scrambled, and computes every output arithmetically. Only these scenarios can show the reset readback, the replace-whole-word behaviour of enable writes and that forwarding does not depend on the enable word.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;

   // word index inside the 8-byte register window
   typedef enum logic {
      SEL_ENABLE = 1'b0,
      SEL_STATUS = 1'b1
   } reg_word_e;

   localparam int WINDOW_BYTES = 8;
   localparam int WORD_BYTES   = 4;

   function automatic reg_word_e decode_word(input logic sel);
      return reg_word_e'(sel);
   endfunction

   // low-order run of ones, NUM_BITS wide result computed in 64 bits
   function automatic logic [63:0] low_ones(input int count);
      logic [63:0] v;
      v = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < count) v[i] = 1'b1;
      end
      return v;
   endfunction

endpackage

// File: rtl/irq_l2_regs.sv
module irq_l2_regs
   import irq_l2_pkg::*;
#(
   parameter int                   NUM_LINES = 32,
   parameter logic [NUM_LINES-1:0] CONN_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sel_i,
   input  logic                 wr_i,
   input  logic [NUM_LINES-1:0] wdata_i,
   input  logic [NUM_LINES-1:0] status_i,
   output logic [NUM_LINES-1:0] enable_o,
   output logic [NUM_LINES-1:0] rdata_o
);

   reg_word_e                word;
   logic [NUM_LINES-1:0]     enable_q;

   assign word = decode_word(sel_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         enable_q <= '0;
      end else if (wr_i && (word == SEL_ENABLE)) begin
         enable_q <= wdata_i & CONN_MASK;
      end
   end

   always_comb begin
      unique case (word)
         SEL_ENABLE: rdata_o = enable_q;
         SEL_STATUS: rdata_o = status_i;
         default:    rdata_o = '0;
      endcase
   end

   assign enable_o = enable_q;

endmodule

// File: rtl/irq_l2_status.sv
module irq_l2_status #(
   parameter int                   NUM_LINES    = 32,
   parameter logic [NUM_LINES-1:0] CAPTURE_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LINES-1:0] lines_i,
   output logic [NUM_LINES-1:0] status_o
);

   logic [NUM_LINES-1:0] status_q;

   always_ff @(posedge clk) begin
      if (rst) status_q <= '0;
      else     status_q <= lines_i & CAPTURE_MASK;
   end

   assign status_o = status_q;

endmodule

// File: rtl/irq_l2_group.sv
module irq_l2_group #(
   parameter int                                   NUM_LINES  = 32,
   parameter int                                   NUM_GROUPS = 2,
   parameter logic [NUM_GROUPS-1:0][NUM_LINES-1:0] MAP_MASKS  = '0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_LINES-1:0]  status_i,
   input  logic [NUM_LINES-1:0]  enable_i,
   output logic [NUM_GROUPS-1:0] grp_o
);

   logic [NUM_LINES-1:0] pending;

   assign pending = status_i & enable_i;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic hit_q;
      always_ff @(posedge clk) begin
         if (rst) hit_q <= 1'b0;
         else     hit_q <= |(pending & MAP_MASKS[g]);
      end
      assign grp_o[g] = hit_q;
   end

endmodule

// File: rtl/irq_l2_bypass.sv
module irq_l2_bypass #(
   parameter int                 NUM_FWD  = 3,
   parameter logic [NUM_FWD-1:0] FWD_MASK = '1
) (
   input  logic [NUM_FWD-1:0] lines_i,
   output logic [NUM_FWD-1:0] fwd_o
);

   for (genvar i = 0; i < NUM_FWD; i++) begin : g_mux
      assign fwd_o[i] = FWD_MASK[i] ? lines_i[i] : 1'b0;
   end

endmodule

// File: rtl/irq_l2_agg.sv
module irq_l2_agg
   import irq_l2_pkg::*;
#(
   parameter int                                   NUM_LINES     = 32,
   parameter int                                   NUM_CONNECTED = 12,
   parameter int                                   NUM_GROUPS    = 2,
   parameter logic [NUM_GROUPS-1:0][NUM_LINES-1:0] MAP_MASKS     = {32'h0000_0140, 32'h0000_0EB8},
   parameter int                                   NUM_FWD       = 3,
   parameter logic [NUM_FWD-1:0]                   FWD_MASK      = 3'b111
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  reg_sel,
   input  logic                  reg_wr,
   input  logic [NUM_LINES-1:0]  reg_wdata,
   output logic [NUM_LINES-1:0]  reg_rdata,
   input  logic [NUM_LINES-1:0]  irq_lines,
   output logic [NUM_GROUPS-1:0] grp_irq,
   output logic [NUM_FWD-1:0]    fwd_irq
);

   localparam logic [63:0]          CONN_WIDE    = low_ones(NUM_CONNECTED);
   localparam logic [NUM_LINES-1:0] CONN_MASK    = CONN_WIDE[NUM_LINES-1:0];
   localparam logic [NUM_LINES-1:0] FWD_LINES    = NUM_LINES'(FWD_MASK);
   localparam logic [NUM_LINES-1:0] CAPTURE_MASK = CONN_MASK & ~FWD_LINES;

   // elaboration-time parameter checks
   if (NUM_LINES < 1 || NUM_LINES > WINDOW_BYTES / 2 * WORD_BYTES * 2) begin : g_bad_lines
      $error("irq_l2_agg: NUM_LINES must be 1..32");
   end
   if (NUM_CONNECTED < 1 || NUM_CONNECTED > NUM_LINES) begin : g_bad_conn
      $error("irq_l2_agg: NUM_CONNECTED out of range");
   end
   if (NUM_FWD < 1 || NUM_FWD > NUM_CONNECTED) begin : g_bad_fwd
      $error("irq_l2_agg: forwarded lines must be connected lines");
   end
   if (NUM_GROUPS < 1) begin : g_bad_groups
      $error("irq_l2_agg: at least one group output is needed");
   end
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask_chk
      if ((MAP_MASKS[g] & ~CONN_MASK) != '0) begin : g_bad_map
         $error("irq_l2_agg: map mask selects an unconnected line");
      end
   end

   logic [NUM_LINES-1:0] status_q;
   logic [NUM_LINES-1:0] enable_q;

   irq_l2_status #(
      .NUM_LINES    (NUM_LINES),
      .CAPTURE_MASK (CAPTURE_MASK)
   ) u_status (
      .clk      (clk),
      .rst      (rst),
      .lines_i  (irq_lines),
      .status_o (status_q)
   );

   irq_l2_regs #(
      .NUM_LINES (NUM_LINES),
      .CONN_MASK (CONN_MASK)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .sel_i    (reg_sel),
      .wr_i     (reg_wr),
      .wdata_i  (reg_wdata),
      .status_i (status_q),
      .enable_o (enable_q),
      .rdata_o  (reg_rdata)
   );

   irq_l2_group #(
      .NUM_LINES  (NUM_LINES),
      .NUM_GROUPS (NUM_GROUPS),
      .MAP_MASKS  (MAP_MASKS)
   ) u_group (
      .clk      (clk),
      .rst      (rst),
      .status_i (status_q),
      .enable_i (enable_q),
      .grp_o    (grp_irq)
   );

   irq_l2_bypass #(
      .NUM_FWD  (NUM_FWD),
      .FWD_MASK (FWD_MASK)
   ) u_bypass (
      .lines_i (irq_lines[NUM_FWD-1:0]),
      .fwd_o   (fwd_irq)
   );

endmodule

// File: rtl/irq_l2_chk.sv
module irq_l2_chk #(
   parameter int                                   NUM_LINES     = 32,
   parameter int                                   NUM_CONNECTED = 12,
   parameter int                                   NUM_GROUPS    = 2,
   parameter logic [NUM_GROUPS-1:0][NUM_LINES-1:0] MAP_MASKS     = '0,
   parameter int                                   NUM_FWD       = 3,
   parameter logic [NUM_FWD-1:0]                   FWD_MASK      = '1
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  reg_sel,
   input logic                  reg_wr,
   input logic [NUM_LINES-1:0]  reg_wdata,
   input logic [NUM_LINES-1:0]  reg_rdata,
   input logic [NUM_LINES-1:0]  irq_lines,
   input logic [NUM_GROUPS-1:0] grp_irq,
   input logic [NUM_FWD-1:0]    fwd_irq,
   input logic [NUM_LINES-1:0]  enable_q
);

   localparam logic [63:0]          CONN_WIDE = irq_l2_pkg::low_ones(NUM_CONNECTED);
   localparam logic [NUM_LINES-1:0] CONN      = CONN_WIDE[NUM_LINES-1:0];
   localparam logic [NUM_LINES-1:0] CAPTURE   = CONN & ~NUM_LINES'(FWD_MASK);

   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)             warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (grp_irq == '0 && enable_q == '0));

   // R2
   enable_load_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && !reg_sel) |=> (enable_q == ($past(reg_wdata) & CONN)));

   // R3
   status_ro_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_sel) |=> $stable(enable_q));

   // R7
   status_unwired_chk: assert property (@(posedge clk) disable iff (rst)
      reg_sel |-> ((reg_rdata & ~CAPTURE) == '0));

   // R6
   fwd_gate_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(fwd_irq & ~FWD_MASK) == 0) && ((fwd_irq & ~irq_lines[NUM_FWD-1:0]) == '0));

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_chk
      // R5
      group_or_chk: assert property (@(posedge clk) disable iff (rst)
         (warm >= 2'd2) |-> (grp_irq[g] ==
            |($past(irq_lines, 2) & $past(enable_q) & MAP_MASKS[g] & CAPTURE)));
   end

endmodule

bind irq_l2_agg irq_l2_chk #(
   .NUM_LINES     (NUM_LINES),
   .NUM_CONNECTED (NUM_CONNECTED),
   .NUM_GROUPS    (NUM_GROUPS),
   .MAP_MASKS     (MAP_MASKS),
   .NUM_FWD       (NUM_FWD),
   .FWD_MASK      (FWD_MASK)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .reg_sel   (reg_sel),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_lines (irq_lines),
   .grp_irq   (grp_irq),
   .fwd_irq   (fwd_irq),
   .enable_q  (enable_q)
);

// File: tb/irq_l2_agg_tb.sv
`timescale 1ns/1ps
module irq_l2_agg_tb;

   localparam logic [31:0] CONN = 32'h0000_0FFF;
   localparam logic [31:0] FWD  = 32'h0000_0007;
   localparam logic [31:0] M0   = 32'h0000_0EB8;
   localparam logic [31:0] M1   = 32'h0000_0140;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] irq_lines = '0;
   logic [1:0]  grp_irq;
   logic [2:0]  fwd_irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   irq_l2_agg u_dut (
      .clk       (clk),
      .rst       (rst),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_lines (irq_lines),
      .grp_irq   (grp_irq),
      .fwd_irq   (fwd_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [31:0] data);
      @(negedge clk);
      reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic sel, output logic [31:0] data);
      reg_sel = sel;
      #1;
      data = reg_rdata;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
      end
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] en_set [3];
      en_set[0] = 32'hFFFF_FFFF;
      en_set[1] = 32'h0000_0A5A;
      en_set[2] = 32'h0000_0000;

      // R1: inputs high during reset, nothing may show
      irq_lines = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      rd_reg(1'b0, rd); check("R1 enable after reset", rd, 32'h0);
      rd_reg(1'b1, rd); check("R1 status after reset", rd, 32'h0);
      check("R1 group after reset", {30'b0, grp_irq}, 32'h0);
      irq_lines = '0;
      @(negedge clk);

      // R2: load and mask
      wr_reg(1'b0, 32'hFFFF_FFFF);
      rd_reg(1'b0, rd); check("R2 enable masked to connected", rd, 32'h0000_0FFF);
      wr_reg(1'b0, 32'h1234_5A5A);
      rd_reg(1'b0, rd); check("R2 enable pattern", rd, 32'h0000_0A5A);

      // R8: whole-word replace
      wr_reg(1'b0, 32'h0000_00F0);
      rd_reg(1'b0, rd); check("R8 enable replaced", rd, 32'h0000_00F0);

      // R3: status write ignored
      irq_lines = 32'h0000_0010;
      wr_reg(1'b1, 32'hFFFF_FFFF);
      rd_reg(1'b0, rd); check("R3 enable untouched", rd, 32'h0000_00F0);
      rd_reg(1'b1, rd); check("R3 status unchanged by write", rd, 32'h0000_0010);
      irq_lines = '0;
      @(negedge clk);

      // R4 R5 R6 R7: sweep
      for (int e = 0; e < 3; e++) begin
         logic [31:0] en;
         en = en_set[e] & CONN;
         wr_reg(1'b0, en_set[e]);
         reg_sel = 1'b1;
         for (int p = 0; p < 4096; p++) begin
            logic [31:0] pat, st, pend;
            logic [1:0]  g_exp;
            pat  = {20'(p * 37) ^ 20'hA5C3F, 12'(p)};
            st   = pat & CONN & ~FWD;
            pend = st & en;
            g_exp = {|(pend & M1), |(pend & M0)};
            irq_lines = pat;
            #1;
            check("R6 forwarded lines", {29'b0, fwd_irq}, pat & FWD);
            @(negedge clk);
            check("R4 R7 status capture", reg_rdata, st);
            @(negedge clk);
            check("R5 group outputs", {30'b0, grp_irq}, {30'b0, g_exp});
         end
      end

      // R7: only unwired lines high
      irq_lines = 32'hFFFF_F000;
      wr_reg(1'b0, 32'hFFFF_FFFF);
      @(negedge clk);
      rd_reg(1'b1, rd); check("R7 unwired status", rd, 32'h0);
      check("R7 unwired groups", {30'b0, grp_irq}, 32'h0);
      check("R7 unwired forwards", {29'b0, fwd_irq}, 32'h0);

      done = 1'b1;
      summary();
   end

endmodule